// File: doc/BRIEF.md
# Dual-Read Paged Register File

This block is the operand store of a small processor datapath. It keeps 64 words of 32 bits in each of two banks that always hold identical contents. Because the banks are copies of each other, two operands can be fetched at the same time, one on the X read bus and one on the Y read bus. A result presented on the Z input bus is written into both banks in the same write.

An entry is addressed by a 5-bit register select together with a 1-bit page select, which is the most significant address bit. Each read bus has its own register select and its own transfer enable. A disabled bus drives zeros, and register 0 always reads as zero.

The block sets its own timing. A six-phase sequencer runs on the system clock and produces a write strobe that is low only in phase 4. It also produces a pair of two-phase clocks for the rest of the datapath, and it counts complete cycles. Reads are combinational from the stored contents. Inputs are expected to be held steady from phase 1 through phase 5.

Top module: `paged_dual_regfile`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, `phase` becomes 0 and `cycle_cnt` becomes 0. A reset applied in the middle of a cycle restarts the sequence at phase 0. Stored register contents are not cleared by reset.
- R2: `phase` advances by one on every clock edge, counting 0,1,2,3,4,5 and then wrapping to 0. `cycle_cnt` increments by one on each wrap from 5 to 0 and holds its value otherwise.
- R3: `wr_strobe` is low during phase 4 and high during every other phase. A write is captured on its rising edge, which is the clock edge that moves phase 4 to phase 5.
- R4: `ph1` is high in phases 0, 1 and 2 and low in phases 3, 4 and 5. `ph2` is low in phases 1 and 4 and high in all other phases.
- R5: At the clock edge that ends phase 4, `z_data` is stored at address {`page`, `z_sel`} in both banks. Before that edge a read of the entry returns the old value. From phase 5 onward a read returns the new value.
- R6: When `x_en` is 0, `x_bus` is all zeros. When `y_en` is 0, `y_bus` is all zeros. Each enable gates only its own bus.
- R7: When a bus is enabled and its select is 0, that bus reads zero, even after a nonzero value has been written to register 0.
- R8: The `page` bit is address bit 5. The same register number on page 0 and on page 1 refers to two independent entries.
- R9: An entry keeps its value unless a write edge occurs while that exact page and register are on `page` and `z_sel`. Changing `z_sel` or `z_data` in any other phase has no effect.
- R10: An enabled bus with a nonzero select shows the stored value of {`page`, select} combinationally, in the same cycle the select is applied. Both buses can show different entries at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page | input | 1 | Page select, address bit 5 |
| x_sel | input | 5 | Register select for X read bus |
| y_sel | input | 5 | Register select for Y read bus |
| z_sel | input | 5 | Register select for write |
| x_en | input | 1 | X transfer enable |
| y_en | input | 1 | Y transfer enable |
| z_data | input | 32 | Write data |
| x_bus | output | 32 | X read bus |
| y_bus | output | 32 | Y read bus |
| phase | output | 3 | Current phase, 0 to 5 |
| cycle_cnt | output | 8 | Completed-cycle counter |
| wr_strobe | output | 1 | Write strobe, low in phase 4 |
| ph1 | output | 1 | First two-phase clock |
| ph2 | output | 1 | Second two-phase clock |

## Verification
The bench reads an entry during phase 4, before its write edge, and again in phase 5. A design that captured one edge early or one edge late would return the wrong value at one of those two points. It writes a nonzero value to register 0 and reads it on both buses, which exposes a zero register that is not actually forced to zero. It writes the same register number on both pages, which exposes an address that drops the page bit.

It also moves `z_sel` to a different register just before phase 4. A design that wrote on any phase other than 4 would then corrupt the register that was selected earlier. Finally, it drives each enable low while the other bus stays enabled. A swapped gate, or a gate shared by both buses, would show up as a wrong value on one of the buses.

// File: rtl/rf_pkg.sv
// Package: shared constants for the paged dual-read register file.
// Assumes: six-phase timing with the write captured at the end of phase 4.
package rf_pkg;
    localparam int RF_DATA_W  = 32;
    localparam int RF_SEL_W   = 5;
    localparam int RF_PHASES  = 6;
    localparam int RF_WR_PH   = 4;
    localparam int RF_CYC_W   = 8;
endpackage

// File: rtl/rf_phase_seq.sv
// Module: rf_phase_seq
// Counts phases 0..PHASES-1 on the system clock and counts the wraps.
// From the phase it derives the write strobe and the two-phase clocks.
// Assumes: synchronous active-low reset. PHASES >= 5, so that phases
// 0..4 used by ph1/ph2 exist.
module rf_phase_seq #(
    parameter int PHASES = rf_pkg::RF_PHASES,
    parameter int WR_PH  = rf_pkg::RF_WR_PH,
    parameter int CYC_W  = rf_pkg::RF_CYC_W,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PH_W-1:0]  phase,
    output logic [CYC_W-1:0] cycle_cnt,
    output logic             wr_strobe,
    output logic             wr_fire,
    output logic             ph1,
    output logic             ph2
);
    localparam logic [PH_W-1:0] LAST_PH  = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] WRITE_PH = PH_W'(WR_PH);

    // Advance the phase, wrap at the last phase and count the wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            cycle_cnt <= '0;
        end else if (phase == LAST_PH) begin
            phase     <= '0;
            cycle_cnt <= cycle_cnt + CYC_W'(1);
        end else begin
            phase     <= phase + PH_W'(1);
        end
    end

    // Decode the strobe and the two-phase clocks from the phase value.
    always_comb begin
        wr_fire   = (phase == WRITE_PH);
        wr_strobe = !wr_fire;
        ph1       = (phase <= PH_W'(2));
        ph2       = !((phase == PH_W'(1)) || (phase == PH_W'(4)));
    end
endmodule

// File: rtl/rf_bank.sv
// Module: rf_bank
// One bank of DEPTH words. It has one synchronous write port and one
// combinational read port.
// Assumes: contents are not reset. Writing on the edge where wr_en is high
// is the same as writing on the rising edge of the write strobe.
module rf_bank #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ADDR_W = rf_pkg::RF_SEL_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write data at the end of the write phase.
    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= wdata;
    end

    // Return the addressed word without delay.
    assign rdata = mem[raddr];
endmodule

// File: rtl/rf_read_gate.sv
// Module: rf_read_gate
// Drives one read bus. It outputs zeros when the bus is disabled or when
// the select names register 0; otherwise it passes the bank word through.
// Assumes: rdata already corresponds to {page, sel}.
module rf_read_gate #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int SEL_W  = rf_pkg::RF_SEL_W
) (
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus
);
    // Gate the word by the enable and the zero-register rule.
    always_comb begin
        bus = '0;
        if (en && (sel != '0)) bus = rdata;
    end
endmodule

// File: rtl/paged_dual_regfile.sv
// Module: paged_dual_regfile
// A paged register file with two read buses. Two mirrored banks serve the
// X and Y buses; each write goes to both banks at the end of phase 4 of
// the six-phase cycle.
// Assumes: selects, enables and z_data are held from phase 1 to phase 5.
module paged_dual_regfile #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int SEL_W  = rf_pkg::RF_SEL_W,
    parameter int PHASES = rf_pkg::RF_PHASES,
    parameter int WR_PH  = rf_pkg::RF_WR_PH,
    parameter int CYC_W  = rf_pkg::RF_CYC_W,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page,
    input  logic [SEL_W-1:0]  x_sel,
    input  logic [SEL_W-1:0]  y_sel,
    input  logic [SEL_W-1:0]  z_sel,
    input  logic              x_en,
    input  logic              y_en,
    input  logic [DATA_W-1:0] z_data,
    output logic [DATA_W-1:0] x_bus,
    output logic [DATA_W-1:0] y_bus,
    output logic [PH_W-1:0]   phase,
    output logic [CYC_W-1:0]  cycle_cnt,
    output logic              wr_strobe,
    output logic              ph1,
    output logic              ph2
);
    localparam int ADDR_W = SEL_W + 1;
    localparam int NBUS   = 2;

    logic              wr_fire;
    logic [ADDR_W-1:0] waddr;
    logic [SEL_W-1:0]  rd_sel [NBUS];
    logic              rd_en  [NBUS];
    logic [DATA_W-1:0] rd_word[NBUS];
    logic [DATA_W-1:0] rd_bus [NBUS];

    rf_phase_seq #(
        .PHASES(PHASES), .WR_PH(WR_PH), .CYC_W(CYC_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cycle_cnt(cycle_cnt),
        .wr_strobe(wr_strobe), .wr_fire(wr_fire), .ph1(ph1), .ph2(ph2)
    );

    // Form the write address with the page as its top bit.
    assign waddr = {page, z_sel};

    // Map the bus-specific selects and enables onto the per-bank arrays.
    always_comb begin
        rd_sel[0] = x_sel;
        rd_sel[1] = y_sel;
        rd_en[0]  = x_en;
        rd_en[1]  = y_en;
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bank
        rf_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
            .clk(clk), .wr_en(wr_fire), .waddr(waddr), .wdata(z_data),
            .raddr({page, rd_sel[b]}), .rdata(rd_word[b])
        );
        rf_read_gate #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_gate (
            .en(rd_en[b]), .sel(rd_sel[b]), .rdata(rd_word[b]), .bus(rd_bus[b])
        );
    end

    assign x_bus = rd_bus[0];
    assign y_bus = rd_bus[1];
endmodule

// File: rtl/rf_checker.sv
// Module: rf_checker
// Assertions on the port behaviour of paged_dual_regfile. Attached by bind.
module rf_checker #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int SEL_W  = rf_pkg::RF_SEL_W,
    parameter int PHASES = rf_pkg::RF_PHASES,
    parameter int CYC_W  = rf_pkg::RF_CYC_W,
    localparam int PH_W  = $clog2(PHASES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              page,
    input logic [SEL_W-1:0]  x_sel,
    input logic [SEL_W-1:0]  z_sel,
    input logic              x_en,
    input logic              y_en,
    input logic [SEL_W-1:0]  y_sel,
    input logic [DATA_W-1:0] z_data,
    input logic [DATA_W-1:0] x_bus,
    input logic [DATA_W-1:0] y_bus,
    input logic [PH_W-1:0]   phase,
    input logic [CYC_W-1:0]  cycle_cnt,
    input logic              wr_strobe,
    input logic              ph1,
    input logic              ph2
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_PH) |=> (phase == $past(phase) + PH_W'(1))); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PH) |=> (phase == '0) && (cycle_cnt == $past(cycle_cnt) + CYC_W'(1))); // R2
    AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_PH) |=> $stable(cycle_cnt)); // R2
    AST_STROBE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_strobe) |-> (phase == PH_W'(4))); // R3
    AST_STROBE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_strobe) |-> (phase == PH_W'(5))); // R3
    AST_PH1_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph1) |-> (phase == '0)); // R4
    AST_PH2_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph2) |-> ((phase == PH_W'(1)) || (phase == PH_W'(4)))); // R4
    AST_X_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !x_en |-> (x_bus == '0)); // R6
    AST_Y_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !y_en |-> (y_bus == '0)); // R6
    AST_X_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (x_sel == '0) |-> (x_bus == '0)); // R7
    AST_Y_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (y_sel == '0) |-> (y_bus == '0)); // R7
    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase == PH_W'(4) && x_sel == z_sel && x_sel != '0)
         && $stable(x_sel) && $stable(page) && x_en)
        |-> (x_bus == $past(z_data))); // R5
endmodule

bind paged_dual_regfile rf_checker #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .PHASES(PHASES), .CYC_W(CYC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .page(page), .x_sel(x_sel), .z_sel(z_sel),
    .x_en(x_en), .y_en(y_en), .y_sel(y_sel), .z_data(z_data),
    .x_bus(x_bus), .y_bus(y_bus), .phase(phase), .cycle_cnt(cycle_cnt),
    .wr_strobe(wr_strobe), .ph1(ph1), .ph2(ph2)
);

// File: tb/sim_paged_dual_regfile.sv
// Directed bench for paged_dual_regfile: one task per scenario.
module sim_paged_dual_regfile;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page = 1'b0;
    logic [4:0]  x_sel = '0, y_sel = '0, z_sel = '0;
    logic        x_en = 1'b0, y_en = 1'b0;
    logic [31:0] z_data = '0;
    logic [31:0] x_bus, y_bus;
    logic [2:0]  phase;
    logic [7:0]  cycle_cnt;
    logic        wr_strobe, ph1, ph2;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    paged_dual_regfile u0 (
        .clk(clk), .rst_n(rst_n), .page(page), .x_sel(x_sel), .y_sel(y_sel),
        .z_sel(z_sel), .x_en(x_en), .y_en(y_en), .z_data(z_data),
        .x_bus(x_bus), .y_bus(y_bus), .phase(phase), .cycle_cnt(cycle_cnt),
        .wr_strobe(wr_strobe), .ph1(ph1), .ph2(ph2)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_phase(input int p);
        do @(negedge clk); while (int'(phase) != p);
    endtask

    // Write d at {pg, r}, idling the write select on register 0 after.
    task automatic do_write(input logic pg, input logic [4:0] r, input logic [31:0] d);
        wait_phase(0);
        page = pg; z_sel = r; z_data = d;
        wait_phase(5);
        z_sel = '0; z_data = '0;
    endtask

    task automatic read_x(input logic pg, input logic [4:0] r, output logic [31:0] v);
        page = pg; x_sel = r; x_en = 1'b1;
        #1 v = x_bus;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 phase", 32'(phase), 32'd0);
        check("R1 cycle", 32'(cycle_cnt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 phase after release", 32'(phase), 32'd1);
    endtask

    task automatic t_phase_seq();
        logic [7:0] c0;
        wait_phase(0);
        c0 = cycle_cnt;
        for (int k = 0; k < 14; k++) begin
            int p = k % 6;
            check("R2 phase", 32'(phase), 32'(p));
            check("R2 cycle", 32'(cycle_cnt), 32'(c0 + 8'(k / 6)));
            check("R3 strobe", 32'(wr_strobe), 32'(p != 4));
            check("R4 ph1", 32'(ph1), 32'(p <= 2));
            check("R4 ph2", 32'(ph2), 32'(!(p == 1 || p == 4)));
            @(negedge clk);
        end
    endtask

    task automatic t_mid_reset();
        logic [31:0] v;
        do_write(1'b0, 5'd21, 32'h0BAD_F00D);
        wait_phase(3);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset phase", 32'(phase), 32'd0);
        check("R1 mid reset cycle", 32'(cycle_cnt), 32'd0);
        read_x(1'b0, 5'd21, v);
        check("R1 contents kept", v, 32'h0BAD_F00D);
        x_en = 1'b0;
    endtask

    task automatic t_write_timing();
        logic [31:0] v;
        do_write(1'b0, 5'd12, 32'h1111_0000);
        wait_phase(0);
        page = 1'b0; z_sel = 5'd12; z_data = 32'hCAFE_1234;
        x_sel = 5'd12; x_en = 1'b1;
        wait_phase(4);
        #1 check("R5 old before edge", x_bus, 32'h1111_0000);
        wait_phase(5);
        #1 check("R5 new after edge", x_bus, 32'hCAFE_1234);
        z_sel = '0; z_data = '0;
        page = 1'b0; y_sel = 5'd12; y_en = 1'b1;
        #1 check("R5 Y bank mirrored", y_bus, 32'hCAFE_1234);
        x_en = 1'b0; y_en = 1'b0;
    endtask

    task automatic t_enable_gate();
        do_write(1'b0, 5'd9, 32'hA5A5_5A5A);
        page = 1'b0; x_sel = 5'd9; y_sel = 5'd9;
        x_en = 1'b0; y_en = 1'b1;
        #1 check("R6 x disabled", x_bus, 32'h0);
        check("R6 y enabled", y_bus, 32'hA5A5_5A5A);
        x_en = 1'b1; y_en = 1'b0;
        #1 check("R6 y disabled", y_bus, 32'h0);
        check("R6 x enabled", x_bus, 32'hA5A5_5A5A);
        x_en = 1'b0;
    endtask

    task automatic t_zero_reg();
        do_write(1'b0, 5'd0, 32'hDEAD_BEEF);
        do_write(1'b1, 5'd0, 32'hFEED_FACE);
        page = 1'b0; x_sel = '0; y_sel = '0; x_en = 1'b1; y_en = 1'b1;
        #1 check("R7 x reg0 page0", x_bus, 32'h0);
        check("R7 y reg0 page0", y_bus, 32'h0);
        page = 1'b1;
        #1 check("R7 x reg0 page1", x_bus, 32'h0);
        x_en = 1'b0; y_en = 1'b0; page = 1'b0;
    endtask

    task automatic t_pages();
        logic [31:0] v;
        do_write(1'b0, 5'd5, 32'h0000_0055);
        do_write(1'b1, 5'd5, 32'h5500_0000);
        read_x(1'b0, 5'd5, v);
        check("R8 page0 entry", v, 32'h0000_0055);
        read_x(1'b1, 5'd5, v);
        check("R8 page1 entry", v, 32'h5500_0000);
        x_en = 1'b0; page = 1'b0;
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_write(1'b0, 5'd3, 32'h3333_3333);
        wait_phase(0);
        page = 1'b0; z_sel = 5'd3; z_data = 32'hBBBB_BBBB;
        wait_phase(4);
        z_sel = 5'd7; z_data = 32'h7777_7777;
        wait_phase(5);
        z_sel = '0; z_data = '0;
        read_x(1'b0, 5'd3, v);
        check("R9 untouched entry", v, 32'h3333_3333);
        read_x(1'b0, 5'd7, v);
        check("R9 selected at write edge", v, 32'h7777_7777);
        x_en = 1'b0;
    endtask

    task automatic t_dual_read();
        do_write(1'b1, 5'd17, 32'h1717_1717);
        do_write(1'b1, 5'd30, 32'h3030_3030);
        page = 1'b1; x_sel = 5'd17; y_sel = 5'd30; x_en = 1'b1; y_en = 1'b1;
        #1 check("R10 x same cycle", x_bus, 32'h1717_1717);
        check("R10 y same cycle", y_bus, 32'h3030_3030);
        x_sel = 5'd30; y_sel = 5'd17;
        #1 check("R10 x after swap", x_bus, 32'h3030_3030);
        check("R10 y after swap", y_bus, 32'h1717_1717);
        x_en = 1'b0; y_en = 1'b0; page = 1'b0;
    endtask

    initial begin
        t_reset();
        t_phase_seq();
        t_write_timing();
        t_enable_gate();
        t_zero_reg();
        t_pages();
        t_hold();
        t_dual_read();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule